// File: doc/BRIEF.md
# Byte-Wide Chain Configuration Loader

This block sits on the host side of a chain of passive, byte-loaded configurable devices and moves their configuration image out of an attached memory. After a start pulse it asks the chain to reset by pulling the shared active-low request line low. It waits for the shared open-drain status line to come back high. It then reads the image from address zero upward and presents one byte per period of a divided configuration clock. Every device in the chain shares the clock, data, request, status and done lines. The loader sees the chain as one target, and it never knows which device is taking the current byte.

If the status line drops during loading, the whole chain is reloaded from the first byte. When auto-restart is selected, the loader waits for the status line to be released and does not touch the request line. Otherwise it drives its own request pulse of the minimum width. After the last byte, a parameterised number of extra clock periods lets the devices initialise. The shared done line is sampled at the end of those periods. A retry counter limits the reloads. When it runs out, a sticky error is raised, and it is cleared only by a new start pulse. A status line that never releases becomes a fatal error once a timeout has elapsed.

Top module: `pcfg_host`

## Requirements
- R1: After reset the request output is high, the configuration clock is low, the data output is 0, and the ok, error and busy outputs are all 0.
- R2: A start pulse in an idle, ok or error state drives the request output low for exactly CLK_MHZ*PULSE_US clock cycles, during which the configuration clock stays low.
- R3: The memory returns the byte for an address one clock after that address is presented. Byte i of the image (address i) is the i-th byte seen at a rising configuration-clock edge, starting with address 0. The data output changes only while the configuration clock is low, and the clock is high for HALF_CYC cycles and low for HALF_CYC cycles.
- R4: After the last of NBYTES bytes, exactly EXTRA_CLKS more rising configuration-clock edges are produced before the done line is judged.
- R5: If the done line is high at the end of the extra clocks, ok goes high, busy goes low, and no further clock edges follow. Ok and error are never high together.
- R6: If the done line is low at the end of the extra clocks, the attempt counts as failed and takes the same retry path as a status error.
- R7: With auto-restart high, a status-low during loading or the extra clocks stops the clock at once. Once status is high again, the image is sent again from byte 0 with no further request pulse.
- R8: With auto-restart low, the same failure produces a new request pulse of the R2 width, and then a reload from byte 0.
- R9: At most MAX_RETRY reloads follow a start. The next failure sets error, which stays high with the clock idle until the next start pulse clears it.
- R10: If status stays low after the request is released, error rises exactly CLK_MHZ*TOUT_US cycles after the request output goes high, with no clock edges and no retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted when idle, ok or in error |
| auto_restart_i | input | 1 | 1: reload after status release; 0: reload through a request pulse |
| mem_addr_o | output | ADDR_W | Image memory address |
| mem_data_i | input | 8 | Memory read data, one cycle after the address |
| cfg_data_o | output | 8 | Configuration byte to the chain |
| cfg_dclk_o | output | 1 | Divided configuration clock |
| cfg_req_n_o | output | 1 | Active-low configuration request to the chain |
| status_n_i | input | 1 | Shared active-low status from the chain |
| done_i | input | 1 | Shared done line from the chain |
| busy_o | output | 1 | Loading sequence in progress |
| ok_o | output | 1 | Chain configured |
| err_o | output | 1 | Sticky fatal error |

## Verification
A wrong byte counter or address shows up at once in the order of bytes captured on the rising clock edges. It can also show up as a missing or extra rising edge, counted before the done line is judged, within the same attempt. A corrupt retry counter or restart path shows up in the number of request pulses and the total number of clock edges only when the attempt ends, so the bench injects a status drop after every possible edge count, in both restart modes. A timer fault appears at the ports as a request pulse of the wrong width, or as an error edge in the wrong cycle, and both are measured to the cycle.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_LOAD,
    ST_INIT,
    ST_OK,
    ST_ERR
  } pcfg_state_e;
endpackage

// File: rtl/pcfg_dclk_gen.sv
// Phase counter for the divided configuration clock: strobes mark the
// cycle in which the clock register rises or falls.
module pcfg_dclk_gen #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int PERIOD = 2 * HALF_CYC;
  localparam int PW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run_i) ph <= '0;
    else if (ph == PW'(PERIOD - 1)) ph <= '0;
    else ph <= ph + 1'b1;
  end

  assign rise_o = run_i && (ph == PW'(HALF_CYC - 1));
  assign fall_o = run_i && (ph == PW'(PERIOD - 1));
endmodule

// File: rtl/pcfg_timer.sv
// Saturating cycle counter, cleared on every state change.
module pcfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) cnt_o <= '0;
    else if (cnt_o != {W{1'b1}}) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/pcfg_host.sv
module pcfg_host
  import pcfg_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int PULSE_US   = 2,
  parameter int TOUT_US    = 100,
  parameter int NBYTES     = 1024,
  parameter int HALF_CYC   = 2,
  parameter int EXTRA_CLKS = 8,
  parameter int MAX_RETRY  = 3,
  parameter int ADDR_W     = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              auto_restart_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic [7:0]        cfg_data_o,
  output logic              cfg_dclk_o,
  output logic              cfg_req_n_o,
  input  logic              status_n_i,
  input  logic              done_i,
  output logic              busy_o,
  output logic              ok_o,
  output logic              err_o
);
  localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
  localparam int TOUT_CYC  = CLK_MHZ * TOUT_US;
  localparam int TMAX      = (PULSE_CYC > TOUT_CYC) ? PULSE_CYC : TOUT_CYC;
  localparam int TW        = $clog2(TMAX + 1);
  localparam int CMAX      = (NBYTES > EXTRA_CLKS) ? NBYTES : EXTRA_CLKS;
  localparam int CW        = $clog2(CMAX + 1);
  localparam int RW        = $clog2(MAX_RETRY + 2);

  pcfg_state_e     state_q, state_d;
  logic [TW-1:0]   tmr;
  logic [CW-1:0]   cnt;
  logic [RW-1:0]   retry;
  logic            fail, rise, fall, run, idle_like;

  assign run       = (state_q == ST_LOAD) || (state_q == ST_INIT);
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_OK) || (state_q == ST_ERR);

  pcfg_timer #(.W(TW)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .clr_i(state_d != state_q),
    .cnt_o(tmr)
  );

  pcfg_dclk_gen #(.HALF_CYC(HALF_CYC)) u_dclk (
    .clk   (clk),
    .rst   (rst),
    .run_i (run),
    .rise_o(rise),
    .fall_o(fall)
  );

  always_comb begin
    state_d = state_q;
    fail    = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_ERR: if (start_i) state_d = ST_REQ;
      ST_REQ:  if (tmr == TW'(PULSE_CYC - 1)) state_d = ST_WAIT;
      // one settle cycle lets the memory return address 0
      ST_WAIT: begin
        if (status_n_i && tmr != '0) state_d = ST_LOAD;
        else if (!status_n_i && tmr == TW'(TOUT_CYC - 1)) state_d = ST_ERR;
      end
      ST_LOAD: begin
        if (!status_n_i) fail = 1'b1;
        else if (fall && cnt == CW'(NBYTES - 1)) state_d = ST_INIT;
      end
      ST_INIT: begin
        if (!status_n_i) fail = 1'b1;
        else if (fall && cnt == CW'(EXTRA_CLKS - 1)) begin
          if (done_i) state_d = ST_OK;
          else fail = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (fail) begin
      if (retry == '0) state_d = ST_ERR;
      else if (auto_restart_i) state_d = ST_WAIT;
      else state_d = ST_REQ;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      cfg_req_n_o <= 1'b1;
      cfg_dclk_o  <= 1'b0;
      cfg_data_o  <= '0;
      mem_addr_o  <= '0;
      cnt         <= '0;
      retry       <= '0;
      ok_o        <= 1'b0;
      err_o       <= 1'b0;
      busy_o      <= 1'b0;
    end else begin
      state_q     <= state_d;
      cfg_req_n_o <= (state_d != ST_REQ);
      ok_o        <= (state_d == ST_OK);
      err_o       <= (state_d == ST_ERR);
      busy_o      <= (state_d == ST_REQ) || (state_d == ST_WAIT) ||
                     (state_d == ST_LOAD) || (state_d == ST_INIT);

      if (idle_like && start_i) retry <= RW'(MAX_RETRY);
      else if (fail && retry != '0) retry <= retry - 1'b1;

      if (state_d == ST_LOAD && state_q != ST_LOAD) begin
        cfg_data_o <= mem_data_i;
        mem_addr_o <= ADDR_W'(1);
        cnt        <= '0;
        cfg_dclk_o <= 1'b0;
      end else if (state_d == ST_LOAD) begin
        if (rise) cfg_dclk_o <= 1'b1;
        if (fall) begin
          cfg_dclk_o <= 1'b0;
          cfg_data_o <= mem_data_i;
          mem_addr_o <= mem_addr_o + 1'b1;
          cnt        <= cnt + 1'b1;
        end
      end else if (state_d == ST_INIT) begin
        if (rise) cfg_dclk_o <= 1'b1;
        if (fall) begin
          cfg_dclk_o <= 1'b0;
          cnt        <= (state_q == ST_LOAD) ? '0 : cnt + 1'b1;
        end
      end else begin
        cfg_dclk_o <= 1'b0;
        mem_addr_o <= '0;
        cnt        <= '0;
      end
    end
  end
endmodule

// File: rtl/pcfg_host_chk.sv
module pcfg_host_chk (
  input logic       clk,
  input logic       rst,
  input logic       start_i,
  input logic       done_i,
  input logic [7:0] cfg_data_o,
  input logic       cfg_dclk_o,
  input logic       cfg_req_n_o,
  input logic       busy_o,
  input logic       ok_o,
  input logic       err_o
);
  // R3
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_dclk_o |-> $stable(cfg_data_o));

  // R2
  req_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_req_n_o |-> !cfg_dclk_o);

  // R3
  dclk_busy_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_dclk_o |-> busy_o);

  // R5
  ok_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ok_o) |-> $past(done_i));

  // R5
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(ok_o && err_o));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> err_o);
endmodule

bind pcfg_host pcfg_host_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .done_i     (done_i),
  .cfg_data_o (cfg_data_o),
  .cfg_dclk_o (cfg_dclk_o),
  .cfg_req_n_o(cfg_req_n_o),
  .busy_o     (busy_o),
  .ok_o       (ok_o),
  .err_o      (err_o)
);

// File: tb/tb_pcfg_host.sv
`timescale 1ns/1ps
module tb_pcfg_host;
  localparam int CLK_MHZ = 2, PULSE_US = 2, TOUT_US = 100;
  localparam int NB = 6, HC = 2, EX = 3, MR = 2, AW = 3;
  localparam int PULSE = CLK_MHZ * PULSE_US;
  localparam int TOUT  = CLK_MHZ * TOUT_US;
  localparam int PER   = NB + EX;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, auto_r = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_q = 8'h00, cfg_data;
  logic dclk, req_n, busy, ok, err;
  logic status_n, done;

  int nchk = 0, nerr = 0, cyc = 0;
  int nrise = 0, base = 0, npulse = 0, lowcnt = 0, last_w = 0, lowleft = 0;
  int fail_at = -1;
  bit done_en = 0, hold_low = 0, prev_dclk = 0, prev_req = 1, wd_hit = 0;
  logic [7:0] cap [0:63];

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  always_ff @(posedge clk) mem_q <= pat(int'(mem_addr));

  assign status_n = (lowleft == 0) && !hold_low;
  assign done     = done_en && ((nrise - base) >= NB);

  pcfg_host #(.CLK_MHZ(CLK_MHZ), .PULSE_US(PULSE_US), .TOUT_US(TOUT_US),
              .NBYTES(NB), .HALF_CYC(HC), .EXTRA_CLKS(EX), .MAX_RETRY(MR),
              .ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .start_i(start), .auto_restart_i(auto_r),
    .mem_addr_o(mem_addr), .mem_data_i(mem_q), .cfg_data_o(cfg_data),
    .cfg_dclk_o(dclk), .cfg_req_n_o(req_n), .status_n_i(status_n),
    .done_i(done), .busy_o(busy), .ok_o(ok), .err_o(err));

  always @(negedge clk) begin
    cyc++;
    if (lowleft > 0) lowleft--;
    if (dclk && !prev_dclk) begin
      if (nrise - base >= 0 && nrise - base < 64) cap[nrise - base] = cfg_data;
      nrise++;
      if (nrise - base == fail_at) lowleft = 10;
    end
    if (!req_n) lowcnt++;
    if (req_n && !prev_req) begin
      last_w = lowcnt;
      lowcnt = 0;
      npulse++;
    end
    prev_dclk = dclk;
    prev_req  = req_n;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1;
      nchk++; nerr++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000; i++) begin
      if (ok || err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // one start, optional status drop after k rising edges, expect success
  task automatic run_ok(input bit a, input int k);
    int p0;
    int off;
    base = nrise; p0 = npulse; auto_r = a; fail_at = k; done_en = 1;
    kick();
    wait_end();
    off = (k > 0) ? k : 0;
    chk("R5 ok", int'(ok), 1);
    chk("R5 busy low", int'(busy), 0);
    chk("R4 rising edges", nrise - base, off + PER);
    if (k > 0 && a) chk("R7 no extra request pulse", npulse - p0, 1);
    else if (k > 0) chk("R8 request pulses", npulse - p0, 2);
    else chk("R2 one request pulse", npulse - p0, 1);
    chk(a ? "R2 width" : "R8 width", last_w, PULSE);
    for (int i = 0; i < NB; i++)
      chk(k > 0 ? "R7_R8 reload byte" : "R3 byte order",
          int'(cap[off + i]), int'(pat(i)));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_n", int'(req_n), 1);
    chk("R1 dclk", int'(dclk), 0);
    chk("R1 data", int'(cfg_data), 0);
    chk("R1 ok", int'(ok), 0);
    chk("R1 err", int'(err), 0);
    chk("R1 busy", int'(busy), 0);

    // R3 R4 R5 plain load in both modes
    run_ok(1'b1, -1);
    run_ok(1'b0, -1);

    // R7 R8 status drop after every rising-edge count
    for (int a = 0; a < 2; a++)
      for (int k = 1; k <= PER; k++)
        run_ok(a[0], k);

    // R6 R9 done never rises: retries run out
    for (int a = 0; a < 2; a++) begin
      int p0, r1;
      base = nrise; p0 = npulse; auto_r = a[0]; fail_at = -1; done_en = 0;
      kick();
      wait_end();
      chk("R9 err set", int'(err), 1);
      chk("R6 attempts edges", nrise - base, (MR + 1) * PER);
      chk("R8 pulses per attempt", npulse - p0, a ? 1 : MR + 1);
      r1 = nrise;
      repeat (30) @(negedge clk);
      chk("R9 err sticky", int'(err), 1);
      chk("R9 clock idle", nrise - r1, 0);
    end

    // R9 start clears error
    done_en = 1; base = nrise;
    kick();
    chk("R9 err cleared", int'(err), 0);
    chk("R9 busy after start", int'(busy), 1);
    wait_end();
    chk("R9 reload ok", int'(ok), 1);

    // R10 status never released
    begin
      int p0, n;
      base = nrise; p0 = npulse; hold_low = 1; auto_r = 1;
      kick();
      while (req_n) @(negedge clk);
      while (!req_n) @(negedge clk);
      n = 0;
      while (!err && n < 5000) begin
        @(negedge clk);
        n++;
      end
      chk("R10 timeout cycles", n, TOUT);
      chk("R10 no edges", nrise - base, 0);
      chk("R10 single pulse", npulse - p0, 1);
      repeat (20) @(negedge clk);
      chk("R10 err held", int'(err), 1);
      hold_low = 0;
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule